// File: doc/BRIEF.md
# Quadword Branch Prediction Cache

This block steers instruction fetch one four-instruction group at a time. A direct-mapped table with one entry per fetch group is read alongside the instruction cache, using the same fetch index. An entry records whether the group holds a predicted control-flow break. If it does, the entry also gives the cache index of the target group, the lane of the last useful instruction in the current group, and the lane of the target instruction in the group that follows.

Each cycle the block returns three things. The first is the index to fetch next: either the stored target or the current index plus one group. The second is a flag that shows a break was predicted. The third is a four-bit lane-kill mask for the group now being fetched. The mask merges two parts. One part removes lanes past the end of the basic block and comes from the current entry. The other removes lanes before the branch target and is carried over one cycle from the previous group. A group can therefore be trimmed on both sides.

When a branch resolves against the prediction, the resolution logic rewrites the entry through the update port. That port also serves taken branches, fall-through, jumps, indirect jumps, calls and returns, because the table holds a single bit of prediction per group. A write takes the table's only port for that cycle, so the fetch in that cycle is stalled.

Top module: `qgp_top`

## Requirements
- R1: After reset every entry is invalid and the carried target mask is zero, so the first fetch reports no break and no killed lanes.
- R2: When the entry at `fetch_idx` is valid and no update is in progress, `pred_disc` is 1 and `next_idx` equals the stored target index.
- R3: When the entry is invalid and no update is in progress, `pred_disc` is 0 and `next_idx` is `fetch_idx + 1` modulo 1024.
- R4: Lanes are numbered 0 to 3, with lane 0 the lowest-address instruction, and bit i of `lane_kill` belongs to lane i. A valid entry with source lane s sets every bit i with i > s.
- R5: In a cycle with `fetch_adv` = 1 and no update, a valid entry with destination lane d sets the carried mask to the bits i < d, and an invalid entry sets it to zero. The carried mask appears in `lane_kill` from the next cycle onward.
- R6: `lane_kill` is the bitwise OR of the carried destination mask and the current source mask.
- R7: While `fetch_adv` = 0 the carried mask keeps its value.
- R8: An update with `upd_taken` = 1 stores the target, source lane and destination lane at `upd_idx` and marks that entry valid, starting with the next cycle. No other entry changes.
- R9: An update with `upd_taken` = 0 marks the entry at `upd_idx` invalid, starting with the next cycle.
- R10: In a cycle with `upd_en` = 1 the read is stalled. `next_idx` equals `fetch_idx`, `pred_disc` is 0, `lane_kill` is 0, and the carried mask keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_idx | input | 10 | Index of the group being fetched |
| fetch_adv | input | 1 | Fetch moves on to the next group this cycle |
| upd_en | input | 1 | Write the table this cycle |
| upd_idx | input | 10 | Entry to write |
| upd_taken | input | 1 | 1 stores a prediction, 0 clears the entry |
| upd_target | input | 10 | Target group index to store |
| upd_src_lane | input | 2 | Lane of the last instruction of the basic block |
| upd_dst_lane | input | 2 | Lane of the target instruction |
| next_idx | output | 10 | Index of the group to fetch next |
| pred_disc | output | 1 | A break is predicted in the current group |
| lane_kill | output | 4 | Lanes of the current group to discard |

## Verification
`next_idx`, `pred_disc` and the source part of `lane_kill` follow from `fetch_idx` and the table within the same cycle. The checks drive inputs just after a falling edge and sample a short time later, before the next rising edge. A table write is visible from the cycle after the write. The carried target mask shows up in the cycle after an advancing fetch and stays unchanged through stalls and cycles without an advance. A behavioural model in the bench updates its own state just after each rising edge, so that every comparison in the next cycle uses the state that the hardware registered at that edge.

// File: rtl/qgp_pkg.sv
package qgp_pkg;

    localparam int IDX_W  = 10;
    localparam int LANES  = 4;
    localparam int LANE_W = $clog2(LANES);
    localparam int DEPTH  = 1 << IDX_W;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [LANES-1:0]  mask_t;

    typedef struct packed {
        logic  valid;
        idx_t  target;
        lane_t src;
        lane_t dst;
    } entry_t;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        logic  taken;
        idx_t  target;
        lane_t src;
        lane_t dst;
    } update_t;

    // lanes strictly above the end of the basic block
    function automatic mask_t mask_above(input lane_t s);
        mask_t m;
        for (int i = 0; i < LANES; i++) m[i] = (i > int'(s));
        return m;
    endfunction

    // lanes strictly below the branch target
    function automatic mask_t mask_below(input lane_t d);
        mask_t m;
        for (int i = 0; i < LANES; i++) m[i] = (i < int'(d));
        return m;
    endfunction

endpackage

// File: rtl/qgp_table.sv
module qgp_table
    import qgp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  idx_t    rd_idx,
    input  update_t upd,
    output entry_t  rd_entry
);

    logic [DEPTH-1:0] valid_q;
    idx_t             target_q [DEPTH];
    lane_t            src_q    [DEPTH];
    lane_t            dst_q    [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) valid_q <= '0;
        else if (upd.en) valid_q[upd.idx] <= upd.taken;
    end

    always_ff @(posedge clk) begin
        if (upd.en && upd.taken) begin
            target_q[upd.idx] <= upd.target;
            src_q[upd.idx]    <= upd.src;
            dst_q[upd.idx]    <= upd.dst;
        end
    end

    // the single port is taken by the write; the read sees nothing
    always_comb begin
        if (upd.en) begin
            rd_entry = '0;
        end else begin
            rd_entry.valid  = valid_q[rd_idx];
            rd_entry.target = target_q[rd_idx];
            rd_entry.src    = src_q[rd_idx];
            rd_entry.dst    = dst_q[rd_idx];
        end
    end

endmodule

// File: rtl/qgp_next.sv
module qgp_next
    import qgp_pkg::*;
(
    input  idx_t cur_idx,
    input  logic hit,
    input  idx_t hit_target,
    input  logic stall,
    output idx_t nxt_idx,
    output logic disc
);

    always_comb begin
        disc = hit && !stall;
        if (stall)    nxt_idx = cur_idx;
        else if (hit) nxt_idx = hit_target;
        else          nxt_idx = cur_idx + idx_t'(1);
    end

endmodule

// File: rtl/qgp_lanemask.sv
module qgp_lanemask
    import qgp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hit,
    input  lane_t src_lane,
    input  lane_t dst_lane,
    input  logic  advance,
    input  logic  stall,
    output mask_t kill
);

    mask_t carry_q;
    mask_t src_mask;

    always_ff @(posedge clk) begin
        if (rst) carry_q <= '0;
        else if (advance && !stall) carry_q <= hit ? mask_below(dst_lane) : '0;
    end

    always_comb begin
        src_mask = hit ? mask_above(src_lane) : '0;
        kill     = stall ? '0 : (carry_q | src_mask);
    end

endmodule

// File: rtl/qgp_top.sv
module qgp_top
    import qgp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [9:0]  fetch_idx,
    input  logic        fetch_adv,
    input  logic        upd_en,
    input  logic [9:0]  upd_idx,
    input  logic        upd_taken,
    input  logic [9:0]  upd_target,
    input  logic [1:0]  upd_src_lane,
    input  logic [1:0]  upd_dst_lane,
    output logic [9:0]  next_idx,
    output logic        pred_disc,
    output logic [3:0]  lane_kill
);

    update_t upd;
    entry_t  ent;

    assign upd = '{en: upd_en, idx: upd_idx, taken: upd_taken,
                   target: upd_target, src: upd_src_lane, dst: upd_dst_lane};

    qgp_table u_tab (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (fetch_idx),
        .upd      (upd),
        .rd_entry (ent)
    );

    qgp_next u_next (
        .cur_idx    (fetch_idx),
        .hit        (ent.valid),
        .hit_target (ent.target),
        .stall      (upd_en),
        .nxt_idx    (next_idx),
        .disc       (pred_disc)
    );

    qgp_lanemask u_mask (
        .clk      (clk),
        .rst      (rst),
        .hit      (ent.valid),
        .src_lane (ent.src),
        .dst_lane (ent.dst),
        .advance  (fetch_adv),
        .stall    (upd_en),
        .kill     (lane_kill)
    );

endmodule

// File: rtl/qgp_checker.sv
module qgp_checker (
    input logic       clk,
    input logic       rst,
    input logic [9:0] fetch_idx,
    input logic       fetch_adv,
    input logic       upd_en,
    input logic [9:0] upd_idx,
    input logic       upd_taken,
    input logic [9:0] upd_target,
    input logic [1:0] upd_src_lane,
    input logic [1:0] upd_dst_lane,
    input logic [9:0] next_idx,
    input logic       pred_disc,
    input logic [3:0] lane_kill
);

    logic [9:0] seq_idx;
    logic [3:0] lanes_seen;
    assign seq_idx    = fetch_idx + 10'd1;
    assign lanes_seen = {upd_src_lane, upd_dst_lane};

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pred_disc && lane_kill == 4'd0));

    assert_seq_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (!upd_en && !pred_disc) |-> (next_idx == seq_idx));

    assert_no_carry_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(fetch_adv && !upd_en && !pred_disc) && !upd_en && !pred_disc)
        |-> (lane_kill == 4'd0));

    assert_write_visible_R8: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_taken && lanes_seen == lanes_seen)
        ##1 (!upd_en && fetch_idx == $past(upd_idx))
        |-> (pred_disc && next_idx == $past(upd_target)));

    assert_clear_visible_R9: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !upd_taken) ##1 (!upd_en && fetch_idx == $past(upd_idx))
        |-> !pred_disc);

    assert_write_stalls_R10: assert property (@(posedge clk) disable iff (rst)
        upd_en |-> (next_idx == fetch_idx && !pred_disc && lane_kill == 4'd0));

endmodule

bind qgp_top qgp_checker u_chk (.*);

// File: tb/test_qgp_top.sv
module test_qgp_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] fetch_idx = '0;
    logic       fetch_adv = 1'b0;
    logic       upd_en = 1'b0;
    logic [9:0] upd_idx = '0;
    logic       upd_taken = 1'b0;
    logic [9:0] upd_target = '0;
    logic [1:0] upd_src_lane = '0;
    logic [1:0] upd_dst_lane = '0;
    logic [9:0] next_idx;
    logic       pred_disc;
    logic [3:0] lane_kill;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit ref_v   [1024];
    int ref_tgt [1024];
    int ref_src [1024];
    int ref_dst [1024];
    int ref_carry = 0;

    always #10 clk = ~clk;

    qgp_top i_qgp_top (.*);

    function automatic int above(input int s);
        int m = 0;
        for (int i = 0; i < 4; i++) if (i > s) m |= (1 << i);
        return m;
    endfunction

    function automatic int below(input int d);
        int m = 0;
        for (int i = 0; i < 4; i++) if (i < d) m |= (1 << i);
        return m;
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input int idx, input bit adv, input bit ue, input int ui,
                        input bit ut, input int utg, input int us, input int ud,
                        input string tag);
        int e_next, e_kill;
        bit e_pred;
        @(negedge clk);
        fetch_idx = 10'(idx); fetch_adv = adv; upd_en = ue; upd_idx = 10'(ui);
        upd_taken = ut; upd_target = 10'(utg); upd_src_lane = 2'(us); upd_dst_lane = 2'(ud);
        #3;
        if (ue) begin
            e_pred = 0; e_next = idx; e_kill = 0;
        end else begin
            e_pred = ref_v[idx];
            e_next = e_pred ? ref_tgt[idx] : (idx + 1) % 1024;
            e_kill = ref_carry | (e_pred ? above(ref_src[idx]) : 0);
        end
        cmp(tag, "pred_disc", int'(pred_disc), int'(e_pred));
        cmp(tag, "next_idx", int'(next_idx), e_next);
        cmp(tag, "lane_kill", int'(lane_kill), e_kill);
        @(posedge clk);
        #1;
        if (ue) begin
            ref_v[ui] = ut;
            if (ut) begin ref_tgt[ui] = utg; ref_src[ui] = us; ref_dst[ui] = ud; end
        end else if (adv) begin
            ref_carry = ref_v[idx] ? below(ref_dst[idx]) : 0;
        end
    endtask

    task automatic fetch(input int idx, input bit adv, input string tag);
        step(idx, adv, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic write(input int idx, input int ui, input bit ut, input int utg,
                         input int us, input int ud, input string tag);
        step(idx, 1, 1, ui, ut, utg, us, ud, tag);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            ref_v[i] = 0; ref_tgt[i] = 0; ref_src[i] = 0; ref_dst[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: cleared table and carried mask
        fetch(0, 1, "R1");
        fetch(1, 1, "R3");
        fetch(1023, 1, "R3 wrap");

        // R10: write stalls, then R8/R2/R4 on the written entry
        write(17, 5, 1, 200, 1, 2, "R10");
        fetch(5, 1, "R2 R4 R8");
        fetch(200, 1, "R5");
        fetch(6, 1, "R8 neighbour untouched");

        // R6: carried left trim ORed with right trim
        write(9, 200, 1, 7, 2, 0, "R10 stall");
        fetch(5, 1, "R5 carry set");
        fetch(200, 1, "R6");
        fetch(7, 1, "R5 carry zero");

        // R7: hold carried mask while not advancing
        fetch(5, 1, "R7 setup");
        fetch(9, 0, "R7");
        fetch(9, 0, "R7");
        // R10: stall keeps carried mask
        write(9, 600, 1, 3, 3, 3, "R10");
        fetch(9, 1, "R10 carry held");
        fetch(600, 1, "R4 src lane 3");

        // R9: clear the entry
        write(5, 5, 0, 0, 0, 0, "R9");
        fetch(5, 1, "R9");

        // mixed traffic over a small index range
        for (int n = 0; n < 400; n++) begin
            if (($urandom % 4) == 0)
                write($urandom % 16, $urandom % 16, $urandom % 2, $urandom % 16,
                      $urandom % 4, $urandom % 4, "R8 R9 mixed");
            else
                fetch($urandom % 16, $urandom % 2, "R2 R6 mixed");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule